// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Copy Engine

This block moves a run of data words from one memory region to another on behalf of software. Software programs a source pointer, a destination pointer and a transfer count through a four-entry register port. It then writes the control word with the channel enable and the software request set. The engine performs each beat as one read followed by one write on a simple request/acknowledge memory master port.

Each pointer independently steps up or down by the beat size, and the source pointer may instead be held fixed. The beat size is set by the width field. With grouping enabled, one counted unit is four beats rather than one. The end of a transfer is reported by a terminal-count flag, a bus error by a separate sticky error flag, and an optional stop interrupt reflects either flag.

The controller is a three-state machine. IDLE waits for a request. READ holds a read request on the source pointer until it is acknowledged. WRITE holds a write request on the destination pointer until it is acknowledged. The transitions are:
- IDLE -> READ on a request with a non-zero count. IDLE -> IDLE on a request with a zero count, which sets the terminal-count flag.
- READ -> WRITE on a read acknowledge.
- WRITE -> READ on a write acknowledge while more beats remain and the enable is still set.
- WRITE -> IDLE on the acknowledge of the final beat (terminal count), or when the enable is found clear (abort).
- READ -> IDLE or WRITE -> IDLE on a bus error.

Top module: `memcpy_dma`

## Requirements
- R1: After reset all four registers read zero. The select codes are 0 = control, 1 = source pointer, 2 = destination pointer, 3 = count; the count keeps its low 16 bits. Control bits read back at these positions: enable 0, mode 3:2, destination down 4, source down 5, source hold 7, stop interrupt enable 8, grouping 9, width 13:12, demand 15, request 16, terminal count 18, error 20.
- R2: A request (bit 16) is accepted only when the same control write also sets the enable and mode 00. Otherwise no memory access occurs. An accepted request reads back as 0 once the transfer has started.
- R3: Each beat reads the source pointer (mem_we=0) and then writes the data just read to the destination pointer (mem_we=1).
- R4: After each beat each pointer moves by the beat size: 1 byte for width 00, 2 for 01, 4 for 10 and 11. It moves up when its direction bit is 0 and down when it is 1. With the hold bit set the source pointer does not move.
- R5: With grouping off a transfer is count beats. With grouping on it is four times count beats.
- R6: The terminal-count flag is set after the last beat and stays set until a control write with bit 18 at 1. A write with bit 18 at 0 leaves it set.
- R7: A count of zero sets the terminal-count flag with no memory access.
- R8: An error response on any access sets the error flag, clears nothing else, and ends the transfer with no further access. The flag is cleared by a control write with bit 20 at 1.
- R9: Clearing the enable during a transfer stops it after the beat in progress. Neither flag is set.
- R10: irq_stop is high exactly while the stop interrupt enable is set and either flag is set.
- R11: Once mem_req is raised, the request, address and direction hold until mem_ack or mem_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| irq_stop | output | 1 | Stop interrupt |

## Verification
A request written to the control word is accepted on the next clock edge, and the first read request appears one cycle after that. The terminal-count and error flags become readable one cycle after the acknowledge or error that ends the transfer. Because the memory stub inserts a random wait of zero to two cycles before each response, the bench does not fix absolute cycles for completion. Instead it polls the control register at the falling edge until either flag shows, with a bounded timeout. It then compares the access log against beat addresses and data computed in the bench. Register read-back is combinational and is sampled one delta after the falling edge that sets the select.

// File: rtl/memcpy_dma_pkg.sv
package memcpy_dma_pkg;

    // control word bit positions (software decodes these)
    localparam int CB_EN     = 0;
    localparam int CB_MODE   = 2;
    localparam int CB_DDIR   = 4;
    localparam int CB_SDIR   = 5;
    localparam int CB_SFIX   = 7;
    localparam int CB_SIE    = 8;
    localparam int CB_BURST  = 9;
    localparam int CB_WIDTH  = 12;
    localparam int CB_DEMAND = 15;
    localparam int CB_SWREQ  = 16;
    localparam int CB_TC     = 18;
    localparam int CB_ERR    = 20;

    localparam logic [1:0] RS_CTRL = 2'd0;
    localparam logic [1:0] RS_SRC  = 2'd1;
    localparam logic [1:0] RS_DST  = 2'd2;
    localparam logic [1:0] RS_CNT  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } dma_state_e;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic       ddir;
        logic       sdir;
        logic       sfix;
        logic       sie;
        logic       burst;
        logic [1:0] width;
        logic       demand;
        logic       swreq;
        logic       tc;
        logic       err;
    } ctrl_t;

    function automatic logic [2:0] beat_step(input logic [1:0] w);
        case (w)
            2'b00:   beat_step = 3'd1;
            2'b01:   beat_step = 3'd2;
            default: beat_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/memcpy_dma_regs.sv
module memcpy_dma_regs
    import memcpy_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_clr,
    input  logic              set_tc,
    input  logic              set_err,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [CNT_W-1:0]  xfer_cnt
);

    logic              wr_ctrl;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_ctrl = cfg_wr && (cfg_sel == RS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (req_clr) begin
                ctrl_q.swreq <= 1'b0;
            end
            if (wr_ctrl) begin
                ctrl_q.en     <= cfg_wdata[CB_EN];
                ctrl_q.mode   <= cfg_wdata[CB_MODE +: 2];
                ctrl_q.ddir   <= cfg_wdata[CB_DDIR];
                ctrl_q.sdir   <= cfg_wdata[CB_SDIR];
                ctrl_q.sfix   <= cfg_wdata[CB_SFIX];
                ctrl_q.sie    <= cfg_wdata[CB_SIE];
                ctrl_q.burst  <= cfg_wdata[CB_BURST];
                ctrl_q.width  <= cfg_wdata[CB_WIDTH +: 2];
                ctrl_q.demand <= cfg_wdata[CB_DEMAND];
                ctrl_q.swreq  <= cfg_wdata[CB_SWREQ] & cfg_wdata[CB_EN]
                                 & (cfg_wdata[CB_MODE +: 2] == 2'b00);
                if (cfg_wdata[CB_TC]) begin
                    ctrl_q.tc <= 1'b0;
                end
                if (cfg_wdata[CB_ERR]) begin
                    ctrl_q.err <= 1'b0;
                end
            end
            if (set_tc) begin
                ctrl_q.tc <= 1'b1;
            end
            if (set_err) begin
                ctrl_q.err <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            xfer_cnt <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel == RS_SRC) begin
                src_base <= cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_sel == RS_DST) begin
                dst_base <= cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_sel == RS_CNT) begin
                xfer_cnt <= cfg_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[CB_EN]             = ctrl_q.en;
        ctrl_word[CB_MODE +: 2]      = ctrl_q.mode;
        ctrl_word[CB_DDIR]           = ctrl_q.ddir;
        ctrl_word[CB_SDIR]           = ctrl_q.sdir;
        ctrl_word[CB_SFIX]           = ctrl_q.sfix;
        ctrl_word[CB_SIE]            = ctrl_q.sie;
        ctrl_word[CB_BURST]          = ctrl_q.burst;
        ctrl_word[CB_WIDTH +: 2]     = ctrl_q.width;
        ctrl_word[CB_DEMAND]         = ctrl_q.demand;
        ctrl_word[CB_SWREQ]          = ctrl_q.swreq;
        ctrl_word[CB_TC]             = ctrl_q.tc;
        ctrl_word[CB_ERR]            = ctrl_q.err;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            RS_CTRL: cfg_rdata = ctrl_word;
            RS_SRC:  cfg_rdata[ADDR_W-1:0] = src_base;
            RS_DST:  cfg_rdata[ADDR_W-1:0] = dst_base;
            default: cfg_rdata[CNT_W-1:0]  = xfer_cnt;
        endcase
    end

endmodule

// File: rtl/memcpy_dma_ptr.sv
module memcpy_dma_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              hold,
    input  logic              dec,
    input  logic [2:0]        step,
    output logic [ADDR_W-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (advance && !hold) begin
            if (dec) begin
                ptr <= ptr - ADDR_W'(step);
            end else begin
                ptr <= ptr + ADDR_W'(step);
            end
        end
    end

endmodule

// File: rtl/memcpy_dma_fsm.sv
module memcpy_dma_fsm
    import memcpy_dma_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              en,
    input  logic              burst,
    input  logic [CNT_W-1:0]  count,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load,
    output logic              advance,
    output logic              req_clr,
    output logic              set_tc,
    output logic              set_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              busy,
    output logic [DATA_W-1:0] data_q
);

    localparam int BI_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    dma_state_e       state, nxt;
    logic [CNT_W-1:0] cnt_left;
    logic [BI_W-1:0]  beat_idx;
    logic             last_beat;
    logic             unit_last;

    assign last_beat = !burst || (beat_idx == BI_W'(BURST_BEATS - 1));
    assign unit_last = last_beat && (cnt_left == CNT_W'(1));
    assign busy      = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt     = state;
        load    = 1'b0;
        advance = 1'b0;
        req_clr = 1'b0;
        set_tc  = 1'b0;
        set_err = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    req_clr = 1'b1;
                    if (count == '0) begin
                        set_tc = 1'b1;
                    end else begin
                        load = 1'b1;
                        nxt  = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_err) begin
                    set_err = 1'b1;
                    nxt     = ST_IDLE;
                end else if (mem_ack) begin
                    nxt = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_err) begin
                    set_err = 1'b1;
                    nxt     = ST_IDLE;
                end else if (mem_ack) begin
                    advance = 1'b1;
                    if (unit_last) begin
                        set_tc = 1'b1;
                        nxt    = ST_IDLE;
                    end else if (!en) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // counters and data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_left <= '0;
            beat_idx <= '0;
            data_q   <= '0;
        end else begin
            if (load) begin
                cnt_left <= count;
                beat_idx <= '0;
            end else if (advance) begin
                if (last_beat) begin
                    beat_idx <= '0;
                    cnt_left <= cnt_left - CNT_W'(1);
                end else begin
                    beat_idx <= beat_idx + BI_W'(1);
                end
            end
            if ((state == ST_READ) && mem_ack && !mem_err) begin
                data_q <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/memcpy_dma.sv
module memcpy_dma
    import memcpy_dma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq_stop
);

    localparam int NPTR = 2;

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [CNT_W-1:0]  xfer_cnt;
    logic              load, advance, req_clr, set_tc, set_err, busy, go;
    logic [2:0]        step;
    logic [ADDR_W-1:0] base_v [NPTR];
    logic [ADDR_W-1:0] ptr_v  [NPTR];
    logic              hold_v [NPTR];
    logic              dec_v  [NPTR];

    memcpy_dma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_clr   (req_clr),
        .set_tc    (set_tc),
        .set_err   (set_err),
        .ctrl_q    (ctrl_q),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .xfer_cnt  (xfer_cnt)
    );

    assign go   = ctrl_q.en && ctrl_q.swreq && (ctrl_q.mode == 2'b00);
    assign step = beat_step(ctrl_q.width);

    memcpy_dma_fsm #(
        .CNT_W       (CNT_W),
        .DATA_W      (DATA_W),
        .BURST_BEATS (BURST_BEATS)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .en        (ctrl_q.en),
        .burst     (ctrl_q.burst),
        .count     (xfer_cnt),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .load      (load),
        .advance   (advance),
        .req_clr   (req_clr),
        .set_tc    (set_tc),
        .set_err   (set_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .busy      (busy),
        .data_q    (mem_wdata)
    );

    assign base_v[0] = src_base;
    assign base_v[1] = dst_base;
    assign hold_v[0] = ctrl_q.sfix;
    assign hold_v[1] = 1'b0;
    assign dec_v[0]  = ctrl_q.sdir;
    assign dec_v[1]  = ctrl_q.ddir;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        memcpy_dma_ptr #(
            .ADDR_W (ADDR_W)
        ) i_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .base    (base_v[g]),
            .advance (advance),
            .hold    (hold_v[g]),
            .dec     (dec_v[g]),
            .step    (step),
            .ptr     (ptr_v[g])
        );
    end

    assign mem_addr = mem_we ? ptr_v[1] : ptr_v[0];
    assign irq_stop = ctrl_q.sie && (ctrl_q.tc || ctrl_q.err);

endmodule

// File: rtl/memcpy_dma_chk.sv
module memcpy_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              en_q,
    input logic              busy
);

    // R11: an outstanding request keeps its address and direction
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_we))
        else $error("p_hold_r11");

    // R3: a completed read is followed by a write
    p_rw_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && !mem_err |=> mem_req && mem_we)
        else $error("p_rw_order_r3");

    // R3: the write carries the data just read
    p_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && !mem_err |=> mem_wdata == $past(mem_rdata))
        else $error("p_wdata_r3");

    // R8: an error ends the transfer
    p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_err |=> !mem_req)
        else $error("p_err_stop_r8");

    // R2: with the enable clear an idle engine makes no access
    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !en_q |=> !mem_req)
        else $error("p_no_start_r2");

endmodule

bind memcpy_dma memcpy_dma_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .en_q      (ctrl_q.en),
    .busy      (busy)
);

// File: tb/test_memcpy_dma.sv
module test_memcpy_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq_stop;

    int checks = 0;
    int errors = 0;
    int n_acc = 0;
    int n_wr = 0;
    int err_at = 0;
    int lat = 0;
    int viol = 0;
    bit pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        pend_we = 1'b0;
    logic [31:0] log_addr [0:255];
    logic [31:0] log_data [0:255];

    always #10 clk = ~clk;

    memcpy_dma i_memcpy_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .irq_stop  (irq_stop)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] step_of(input int w);
        return (w == 0) ? 32'd1 : (w == 1) ? 32'd2 : 32'd4;
    endfunction

    // memory stub: random wait, logs writes, optional error on one access
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req) begin
                if (pend && (mem_addr != pend_addr || mem_we != pend_we)) viol++;
                if (lat == 0) begin
                    pend = 1'b0;
                    n_acc++;
                    if (n_acc == err_at) begin
                        mem_err = 1'b1;
                    end else begin
                        mem_ack = 1'b1;
                        if (mem_we) begin
                            if (n_wr < 256) begin
                                log_addr[n_wr] = mem_addr;
                                log_data[n_wr] = mem_wdata;
                            end
                            n_wr++;
                        end else begin
                            mem_rdata = pat(mem_addr);
                        end
                    end
                    lat = $urandom % 3;
                end else begin
                    pend = 1'b1;
                    pend_addr = mem_addr;
                    pend_we = mem_we;
                    lat--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = s;
        cfg_wdata = d;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] c);
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, c);
            if (c[18] || c[20]) break;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int w, input bit sd, input bit dd,
                                             input bit sf, input bit bu, input bit sie);
        logic [31:0] v;
        v = 32'h1 | (32'h1 << 16);
        v[13:12] = w[1:0];
        v[5] = sd;
        v[4] = dd;
        v[7] = sf;
        v[9] = bu;
        v[8] = sie;
        return v;
    endfunction

    task automatic run_case(input int w, input bit sd, input bit dd, input bit sf,
                            input bit bu, input int cnt,
                            input logic [31:0] src, input logic [31:0] dst);
        logic [31:0] c, sa, da;
        int beats, bad_a, bad_d;
        n_acc = 0; n_wr = 0; err_at = 0;
        wr(2'd1, src);
        wr(2'd2, dst);
        wr(2'd3, cnt);
        wr(2'd0, mk_ctrl(w, sd, dd, sf, bu, 1'b0));
        wait_done(c);
        beats = cnt * (bu ? 4 : 1);
        chk(c[18] && !c[20], "R6 terminal count set", c, 32'h40000);
        chk(c[16] == 1'b0, "R2 request self-clears", c, 32'h0);
        chk(n_wr == beats, "R5 beat count", n_wr, beats);
        bad_a = 0; bad_d = 0;
        for (int k = 0; k < beats && k < 256; k++) begin
            sa = sf ? src : (sd ? src - k * step_of(w) : src + k * step_of(w));
            da = dd ? dst - k * step_of(w) : dst + k * step_of(w);
            if (log_addr[k] != da) bad_a++;
            if (log_data[k] != pat(sa)) bad_d++;
        end
        chk(bad_a == 0, "R4 destination address sequence", bad_a, 0);
        chk(bad_d == 0, "R3 R4 data read from source sequence", bad_d, 0);
        chk(irq_stop == 1'b0, "R10 no interrupt when disabled", irq_stop, 0);
        wr(2'd0, 32'h1 << 18);
        rd(2'd0, c);
        chk(c[18] == 1'b0, "R6 write-one clears", c, 0);
    endtask

    initial begin
        logic [31:0] c, d;
        int w0, dummy;
        dummy = $urandom(32'd20240601);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), d);
            chk(d == 0, "R1 reset value", d, 0);
        end
        chk(irq_stop == 1'b0, "R10 reset interrupt low", irq_stop, 0);

        // R1 read-back, R2 enable clear blocks request
        n_acc = 0;
        wr(2'd0, 32'h1B3BC);
        repeat (10) @(negedge clk);
        rd(2'd0, d);
        chk(d == 32'hB3BC, "R1 control read-back", d, 32'hB3BC);
        chk(n_acc == 0, "R2 no access with enable clear", n_acc, 0);
        wr(2'd1, 32'hDEADBEE0);
        rd(2'd1, d);
        chk(d == 32'hDEADBEE0, "R1 source pointer read-back", d, 32'hDEADBEE0);
        wr(2'd3, 32'h12345);
        rd(2'd3, d);
        chk(d == 32'h2345, "R1 count keeps low 16 bits", d, 32'h2345);
        wr(2'd0, 32'h10005);
        repeat (10) @(negedge clk);
        rd(2'd0, d);
        chk(n_acc == 0 && d[16] == 1'b0, "R2 non-software mode refused", n_acc, 0);
        wr(2'd0, 32'h0);

        // directed corners
        run_case(2, 1'b0, 1'b0, 1'b0, 1'b0, 3, 32'h100, 32'h800);
        run_case(2, 1'b1, 1'b1, 1'b0, 1'b1, 2, 32'h2000, 32'h3000);
        run_case(0, 1'b0, 1'b1, 1'b1, 1'b0, 4, 32'h101, 32'h903);

        // random mix
        for (int i = 0; i < 10; i++) begin
            run_case($urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1 + $urandom % 3,
                     ($urandom & 32'h0000FFF0) | 32'h10000000,
                     ($urandom & 32'h0000FFF0) | 32'h20000000);
        end

        // R6 writing 0 to the flag does not clear it
        n_acc = 0;
        wr(2'd3, 32'd1);
        wr(2'd0, mk_ctrl(2, 0, 0, 0, 0, 0));
        wait_done(c);
        wr(2'd0, 32'h0);
        rd(2'd0, c);
        chk(c[18] == 1'b1, "R6 zero write keeps flag", c, 32'h40000);
        wr(2'd0, 32'h1 << 18);

        // R7 zero count
        n_acc = 0;
        wr(2'd3, 32'd0);
        wr(2'd0, mk_ctrl(2, 0, 0, 0, 0, 0));
        wait_done(c);
        chk(c[18] == 1'b1, "R7 zero count sets flag", c, 32'h40000);
        chk(n_acc == 0, "R7 zero count makes no access", n_acc, 0);
        wr(2'd0, 32'h1 << 18);

        // R8 bus error on the second read, R10 interrupt
        n_acc = 0; n_wr = 0; err_at = 3;
        wr(2'd1, 32'h400);
        wr(2'd2, 32'h600);
        wr(2'd3, 32'd4);
        wr(2'd0, mk_ctrl(2, 0, 0, 0, 0, 1));
        wait_done(c);
        chk(c[20] && !c[18], "R8 error flag only", c, 32'h100000);
        repeat (20) @(negedge clk);
        chk(n_acc == 3 && n_wr == 1, "R8 no access after error", n_acc, 3);
        chk(irq_stop == 1'b1, "R10 interrupt on error", irq_stop, 1);
        wr(2'd0, 32'h1 << 20);
        rd(2'd0, c);
        chk(c[20] == 1'b0, "R8 error flag write-one clears", c, 0);
        chk(irq_stop == 1'b0, "R10 interrupt drops", irq_stop, 0);
        err_at = 0;

        // R9 abort
        n_acc = 0; n_wr = 0;
        wr(2'd1, 32'h1000);
        wr(2'd2, 32'h1800);
        wr(2'd3, 32'd8);
        wr(2'd0, mk_ctrl(2, 0, 0, 0, 0, 0));
        for (int i = 0; i < 500 && n_wr < 2; i++) @(negedge clk);
        w0 = n_wr;
        wr(2'd0, 32'h00002000);
        repeat (40) @(negedge clk);
        rd(2'd0, c);
        chk(!c[18] && !c[20], "R9 abort sets no flag", c, 0);
        chk(n_wr <= w0 + 2 && n_wr < 8, "R9 abort stops transfer", n_wr, w0);
        chk(n_acc == 2 * n_wr, "R9 abort ends after a whole beat", n_acc, 2 * n_wr);

        chk(viol == 0, "R11 request held stable", viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule